// File: doc/BRIEF.md
# Oversampled Serial Word Receiver

This block takes 16-bit words from one asynchronous serial line. It runs on a free-running sample clock at sixteen times the bit rate. A frame is a low start bit, sixteen data bits sent most significant first, and a high stop bit. Each bit cell lasts sixteen sample clocks. The receiver sees the falling edge of the start bit and checks that bit again at the middle of its cell. It then takes each data bit at the centre of its cell and checks the stop bit last.

When a frame ends with a good stop bit, the word goes into a parallel output register and a one-cycle strobe goes out with it. When the stop bit is low, the output register keeps its old value and a one-cycle pulse appears on the status output. After any frame ends, the receiver needs the line to go high before it accepts another start. A low line that is already low when the receiver goes idle is therefore never mistaken for a new start bit.

Top module: `serial_word_rx`

## Requirements
- R1: While `syncClear` is high at a clock edge, the receiver goes back to waiting for a high line. `wordOut` becomes 0 and `wordValid` and `statusOut` become 0. A frame in progress is dropped and produces no strobe or pulse.
- R2: `serialIn` passes through two register stages before the control logic sees it. Count 0 of a frame is the first clock edge at which the synchronized line reads 0 while the receiver is armed. The stop sample is therefore 282 edges after the first edge that sees `serialIn` low.
- R3: The receiver stays idle while the line is high. After a clear, and after a frame ends with or without an error, it must see the synchronized line at 1 before a low level is taken as a start edge. A line held low after a frame starts nothing.
- R4: At count 8 the start bit is checked again. If it reads 1, the receiver returns to idle. It produces no `wordValid`, no `statusOut` pulse and no change to `wordOut`.
- R5: Data bits are sampled at counts 24 + 16*i for i = 0..15. The first sample becomes bit 15 of the word and the last becomes bit 0.
- R6: The stop bit is sampled at count 280. If it reads 1, `wordOut` takes the received word and `wordValid` is high for exactly the next clock period.
- R7: If the stop sample reads 0, `wordOut` is unchanged and `wordValid` stays low. `statusOut` is high for exactly one clock period, in the cycle after the stop sample.
- R8: `wordValid` and `statusOut` are never high together. Outside a clear, `wordOut` changes only in a cycle where `wordValid` is high.
- R9: A new start bit that follows the stop cell with no idle gap is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16 times the bit rate |
| syncClear | input | 1 | Active-high synchronous clear |
| serialIn | input | 1 | Asynchronous serial data line, idles high |
| wordOut | output | 16 | Last word received with a good stop bit |
| wordValid | output | 1 | One-cycle strobe when `wordOut` is loaded |
| statusOut | output | 1 | One-cycle pulse after a framing error |

## Verification
The bench targets the sample-point arithmetic. It checks the exact cycle of the `wordValid` strobe against the edge where the line first fell. A counter that is off by one, or a synchronizer with the wrong depth, moves that strobe and fails the check. Words such as 0x8001 and 0xA5C3 expose a receiver that packs bits least-significant first or drops the final shift. An error frame followed by a line held low catches a receiver that re-arms while the line is still low, because it would start a spurious frame. A four-cycle low glitch catches one that commits to a frame without the mid-cell check. A clear in mid-frame catches state left over from a half-received word.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_HIGH = 2'd0,
    ST_ARMED     = 2'd1,
    ST_RECV      = 2'd2
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic commit;
    logic frameErr;
  } rxStrobe_t;
endpackage

// File: rtl/serial_word_rx_ctrl.sv
module serial_word_rx_ctrl
  import serial_word_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 16
) (
  input  logic      clk,
  input  logic      syncClear,
  input  logic      rxSync,
  output rxStrobe_t strobe
);
  localparam int HALF       = OVERSAMPLE / 2;
  localparam int FIRST_DATA = HALF + OVERSAMPLE;
  localparam int STOP_AT    = HALF + OVERSAMPLE * (DATA_W + 1);
  localparam int CNT_W      = $clog2(STOP_AT + 1);

  rxState_t           state, stateNext;
  logic [CNT_W-1:0]   cnt, cntNext;
  logic               atCentre;

  assign atCentre = ((cnt % CNT_W'(OVERSAMPLE)) == CNT_W'(HALF));

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    unique case (state)
      ST_WAIT_HIGH: begin
        if (rxSync) stateNext = ST_ARMED;
      end
      ST_ARMED: begin
        if (!rxSync) begin
          stateNext = ST_RECV;
          cntNext   = CNT_W'(1);
        end
      end
      ST_RECV: begin
        cntNext = cnt + CNT_W'(1);
        if (cnt == CNT_W'(HALF)) begin
          if (rxSync) stateNext = ST_WAIT_HIGH;
        end else if (cnt == CNT_W'(STOP_AT)) begin
          stateNext = ST_WAIT_HIGH;
          if (rxSync) strobe.commit   = 1'b1;
          else        strobe.frameErr = 1'b1;
        end else if (cnt >= CNT_W'(FIRST_DATA) && atCentre) begin
          strobe.shiftEn = 1'b1;
        end
      end
      default: stateNext = ST_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (syncClear) begin
      state <= ST_WAIT_HIGH;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  AST_START_FROM_ARMED: assert property (@(posedge clk) disable iff (syncClear)
    (state == ST_RECV && $past(state) != ST_RECV && !$past(syncClear))
      |-> ($past(state) == ST_ARMED && !$past(rxSync))); // R3

  AST_GLITCH_TO_IDLE: assert property (@(posedge clk) disable iff (syncClear)
    (state == ST_RECV && cnt == CNT_W'(HALF) && rxSync) |=> (state == ST_WAIT_HIGH)); // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (syncClear)
    (state == ST_RECV) |-> (cnt <= CNT_W'(STOP_AT))); // R5

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (syncClear)
    $onehot0({strobe.shiftEn, strobe.commit, strobe.frameErr})); // R8
endmodule

// File: rtl/serial_word_rx_dp.sv
module serial_word_rx_dp
  import serial_word_rx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              syncClear,
  input  logic              serialIn,
  input  rxStrobe_t         strobe,
  output logic              rxSync,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              statusOut
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_W-1:0]      shiftReg;

  always_ff @(posedge clk) begin
    if (syncClear) syncChain[0] <= 1'b1;
    else           syncChain[0] <= serialIn;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (syncClear) syncChain[g] <= 1'b1;
      else           syncChain[g] <= syncChain[g-1];
    end
  end

  assign rxSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (syncClear) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      statusOut <= 1'b0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], rxSync};
      if (strobe.commit)  wordOut  <= shiftReg;
      wordValid <= strobe.commit;
      statusOut <= strobe.frameErr;
    end
  end

  AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (syncClear)
    statusOut |=> !statusOut); // R7

  AST_NO_LOAD_ON_ERROR: assert property (@(posedge clk) disable iff (syncClear)
    (statusOut && !$past(syncClear)) |-> (wordOut == $past(wordOut))); // R7

  AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (syncClear)
    !(wordValid && statusOut)); // R8

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (syncClear)
    (!$past(syncClear) && wordOut != $past(wordOut)) |-> wordValid); // R8

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (syncClear)
    wordValid |=> !wordValid); // R6
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import serial_word_rx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              syncClear,
  input  logic              serialIn,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              statusOut
);
  rxStrobe_t strobe;
  logic      rxSync;

  serial_word_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_W     (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .syncClear (syncClear),
    .rxSync    (rxSync),
    .strobe    (strobe)
  );

  serial_word_rx_dp #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .syncClear (syncClear),
    .serialIn  (serialIn),
    .strobe    (strobe),
    .rxSync    (rxSync),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .statusOut (statusOut)
  );
endmodule

// File: tb/serial_word_rx_bench.sv
`timescale 1ns/100ps
module serial_word_rx_bench;
  logic        clk = 1'b0;
  logic        syncClear = 1'b1;
  logic        serialIn = 1'b1;
  logic [15:0] wordOut;
  logic        wordValid;
  logic        statusOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int nValid  = 0;
  int nErr    = 0;
  int validCycle = 0;
  int startCycle = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference state
  int mS1 = 1, mS2 = 1, mSt = 0, mCnt = 0, mShift = 0, mWord = 0;
  int mValid = 0, mStat = 0;

  always #2.5 clk = ~clk;

  serial_word_rx u_serial_word_rx (
    .clk       (clk),
    .syncClear (syncClear),
    .serialIn  (serialIn),
    .wordOut   (wordOut),
    .wordValid (wordValid),
    .statusOut (statusOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    int ln;
    cycles++;
    if (syncClear) begin
      mS1 = 1; mS2 = 1; mSt = 0; mCnt = 0; mShift = 0; mWord = 0; mValid = 0; mStat = 0;
    end else begin
      ln = mS2; mValid = 0; mStat = 0;
      case (mSt)
        0: if (ln == 1) mSt = 1;
        1: if (ln == 0) begin mSt = 2; mCnt = 0; end
        default: begin
          if (mCnt == 8) begin
            if (ln == 1) mSt = 0;
          end else if (mCnt == 280) begin
            if (ln == 1) begin mWord = mShift; mValid = 1; end
            else mStat = 1;
            mSt = 0;
          end else if (mCnt >= 24 && (mCnt - 8) % 16 == 0) begin
            mShift = ((mShift << 1) | ln) & 16'hFFFF;
          end
        end
      endcase
      if (mSt == 2) mCnt++;
      mS2 = mS1; mS1 = int'(serialIn);
    end
    chk(wordOut === 16'(mWord), {phase, " wordOut"}, int'(wordOut), mWord);
    chk(wordValid === 1'(mValid), {phase, " wordValid"}, int'(wordValid), mValid);
    chk(statusOut === 1'(mStat), {phase, " statusOut"}, int'(statusOut), mStat);
    if (wordValid === 1'b1) begin nValid++; validCycle = cycles; end
    if (statusOut === 1'b1) nErr++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic hold(input logic v, input int n);
    serialIn = v;
    repeat (n) tick();
  endtask

  task automatic sendFrame(input logic [15:0] w, input logic stopBit);
    startCycle = cycles;
    hold(1'b0, 16);
    for (int i = 15; i >= 0; i--) hold(w[i], 16);
    hold(stopBit, 16);
  endtask

  initial begin
    int v0, e0;
    logic [15:0] keep;
    repeat (4) tick();
    // R1 reset state
    chk(wordOut === 16'h0, "R1 reset wordOut", int'(wordOut), 0);
    chk(wordValid === 1'b0 && statusOut === 1'b0, "R1 reset strobes", int'({wordValid, statusOut}), 0);
    syncClear = 1'b0;
    hold(1'b1, 30);

    phase = "R5";
    sendFrame(16'hA5C3, 1'b1); hold(1'b1, 20);
    chk(wordOut === 16'hA5C3, "R5 word A5C3", int'(wordOut), 16'hA5C3);
    chk(nValid == 1, "R6 one strobe", nValid, 1);
    chk(validCycle - startCycle == 283, "R2 strobe latency", validCycle - startCycle, 283);

    sendFrame(16'h8001, 1'b1); hold(1'b1, 20);
    chk(wordOut === 16'h8001, "R5 word 8001 MSB first", int'(wordOut), 16'h8001);
    sendFrame(16'h0000, 1'b1); hold(1'b1, 10);
    chk(wordOut === 16'h0000, "R6 word 0000", int'(wordOut), 0);
    sendFrame(16'hFFFF, 1'b1); hold(1'b1, 10);
    chk(wordOut === 16'hFFFF, "R6 word FFFF", int'(wordOut), 16'hFFFF);
    chk(nValid == 4, "R6 strobe count", nValid, 4);

    // R7 framing error
    phase = "R7";
    keep = wordOut; v0 = nValid; e0 = nErr;
    sendFrame(16'h1234, 1'b0); hold(1'b1, 20);
    chk(nErr == e0 + 1, "R7 one error pulse", nErr, e0 + 1);
    chk(wordOut === keep, "R7 word kept", int'(wordOut), int'(keep));
    chk(nValid == v0, "R7 no strobe", nValid, v0);

    // R4 glitch
    phase = "R4";
    v0 = nValid; e0 = nErr;
    hold(1'b0, 4); hold(1'b1, 40);
    chk(nValid == v0 && nErr == e0, "R4 glitch silent", nValid + nErr, v0 + e0);
    chk(wordOut === keep, "R4 word kept", int'(wordOut), int'(keep));

    // R3 line held low after an error frame
    phase = "R3";
    v0 = nValid; e0 = nErr;
    sendFrame(16'h5A5A, 1'b0); hold(1'b0, 60); hold(1'b1, 30);
    chk(nErr == e0 + 1 && nValid == v0, "R3 no restart while low", nErr - e0, 1);
    sendFrame(16'h3C96, 1'b1); hold(1'b1, 20);
    chk(wordOut === 16'h3C96, "R3 recovers", int'(wordOut), 16'h3C96);

    // R9 back-to-back frames
    phase = "R9";
    v0 = nValid;
    sendFrame(16'h1357, 1'b1);
    sendFrame(16'hFEDC, 1'b1); hold(1'b1, 20);
    chk(nValid == v0 + 2, "R9 two strobes", nValid - v0, 2);
    chk(wordOut === 16'hFEDC, "R9 second word", int'(wordOut), 16'hFEDC);

    // R1 clear in mid-frame
    phase = "R1";
    v0 = nValid; e0 = nErr;
    hold(1'b0, 16); hold(1'b1, 40);
    syncClear = 1'b1; tick(); tick();
    chk(wordOut === 16'h0, "R1 clear mid-frame", int'(wordOut), 0);
    syncClear = 1'b0;
    hold(1'b1, 320);
    chk(nValid == v0 && nErr == e0, "R1 dropped frame silent", nValid + nErr, v0 + e0);
    sendFrame(16'h0F0F, 1'b1); hold(1'b1, 20);
    chk(wordOut === 16'h0F0F, "R1 works after clear", int'(wordOut), 16'h0F0F);
    finishRun();
  end
endmodule